// File: doc/BRIEF.md
# CAN Interframe Space Sequencer

This block follows a CAN 2.0B node through the gap between frames. A frame engine tells it when the end-of-frame field of a data or remote frame has finished, or when an error or overload delimiter begins. From then on the sequencer watches the sampled bus level on each bit-time strobe. It counts the delimiter, the three intermission bits, the optional eight-bit suspend field and the bus-idle state. It reports when a new frame starts, when the node may start sending, and when an overload frame has to be raised.

The suspend field is tied to the node's actual role in the previous frame. It is only inserted for an error-passive node that really transmitted that frame. A node that lost arbitration counts as a receiver, skips the suspend field, and may retry at once. A dominant level on the last intermission bit counts as a start of frame. Any node with a pending frame then joins arbitration at the identifier. This also holds for a node that lost arbitration last time.

Top module: `can_ifs_seq`

## Requirements
- R1: While reset is low, and after it, `phase` reads idle and all three pulse outputs are low. Phase codes: 0 idle, 1 in-frame, 2 delimiter, 3 intermission, 4 suspend.
- R2: State changes only on a clock edge where `bit_tick` is high. `sof_det`, `tx_grant` and `ovld_req` are high for exactly the one clock that follows such an edge.
- R3: Intermission is three bits, and `rx_bit` = 1 means recessive. A dominant first or second intermission bit raises `ovld_req` and moves to in-frame.
- R4: A dominant third intermission bit raises `sof_det` and moves to in-frame. `tx_grant` is raised with it when `tx_pending` is high, whatever the value of `was_transmitter`.
- R5: A recessive third intermission bit moves to suspend when `err_passive` and `was_transmitter` are both high. After eight recessive suspend bits the phase becomes idle, and no grant is given during suspend.
- R6: With `was_transmitter` low, a recessive third intermission bit goes straight to idle, even when `err_passive` is high.
- R7: A dominant bit during suspend raises `sof_det` without `tx_grant` and moves to in-frame.
- R8: In idle, a recessive bit with `tx_pending` high raises `tx_grant` and moves to in-frame. A dominant bit raises `sof_det`, with `tx_grant` if a request is pending.
- R9: `delim_begin` in the in-frame phase starts an eight-bit delimiter. A dominant eighth bit raises `ovld_req` and returns to in-frame. A recessive eighth bit starts intermission.
- R10: `frame_done` and `delim_begin` are ignored in every phase other than in-frame. In-frame moves to intermission on `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| err_passive | input | 1 | Node is error passive |
| was_transmitter | input | 1 | Node sent the last frame (0 after lost arbitration) |
| tx_pending | input | 1 | A frame waits to be sent |
| frame_done | input | 1 | With a tick: last end-of-frame bit sampled |
| delim_begin | input | 1 | With a tick: next bit is delimiter bit 1 |
| sof_det | output | 1 | Start of frame seen on the bus |
| tx_grant | output | 1 | Start sending (SOF, or identifier when joining) |
| ovld_req | output | 1 | Overload frame must be sent |
| phase | output | 3 | Current interframe phase code |

## Verification
The properties assume that `frame_done` and `delim_begin` only come together with a tick. They also assume that the role and error flags are settled when the last intermission bit is sampled. Ticks are taken to be single-clock strobes. The stimulus drives all inputs on the falling edge and pulses `bit_tick` for one clock. It leaves at least one tick-free clock between bits, so every registered pulse can be seen rising and then clearing.

// File: rtl/can_ifs_pkg.sv
package can_ifs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FRAME  = 3'd1,
    PH_DELIM  = 3'd2,
    PH_INTERM = 3'd3,
    PH_SUSP   = 3'd4
  } ifs_phase_e;

  typedef struct packed {
    logic sof;
    logic grant;
    logic ovld;
  } ifs_evt_t;

  localparam int unsigned EVT_W = 3;
endpackage

// File: rtl/ifs_bit_index.sv
module ifs_bit_index #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  output logic [CW-1:0] idx
);
  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (en) begin
      if (clr) idx_d = '0;
      else     idx_d = idx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/ifs_phase_ctrl.sv
module ifs_phase_ctrl
  import can_ifs_pkg::*;
#(
  parameter int unsigned INTERM_LEN  = 3,
  parameter int unsigned SUSPEND_LEN = 8,
  parameter int unsigned DELIM_LEN   = 8,
  parameter int unsigned CW          = 3
) (
  input  ifs_phase_e    phase,
  input  logic [CW-1:0] idx,
  input  logic          rx_bit,
  input  logic          err_passive,
  input  logic          was_transmitter,
  input  logic          tx_pending,
  input  logic          frame_done,
  input  logic          delim_begin,
  output ifs_phase_e    nxt_phase,
  output logic          idx_clr,
  output ifs_evt_t      evt
);
  localparam logic [CW-1:0] INT_LAST  = CW'(INTERM_LEN - 1);
  localparam logic [CW-1:0] SUSP_LAST = CW'(SUSPEND_LEN - 1);
  localparam logic [CW-1:0] DEL_LAST  = CW'(DELIM_LEN - 1);

  logic dominant;
  logic int_last, susp_last, del_last;
  logic suspend_due;

  assign dominant    = ~rx_bit;
  assign int_last    = (idx == INT_LAST);
  assign susp_last   = (idx == SUSP_LAST);
  assign del_last    = (idx == DEL_LAST);
  // suspend only for a node that really sent the last frame
  assign suspend_due = err_passive & was_transmitter;

  always_comb begin
    nxt_phase = phase;
    evt       = '0;
    unique case (phase)
      PH_IDLE: begin
        if (dominant) begin
          evt.sof   = 1'b1;
          evt.grant = tx_pending;
          nxt_phase = PH_FRAME;
        end else if (tx_pending) begin
          evt.grant = 1'b1;
          nxt_phase = PH_FRAME;
        end
      end
      PH_FRAME: begin
        if (frame_done)       nxt_phase = PH_INTERM;
        else if (delim_begin) nxt_phase = PH_DELIM;
      end
      PH_DELIM: begin
        if (del_last) begin
          if (dominant) begin
            evt.ovld  = 1'b1;
            nxt_phase = PH_FRAME;
          end else begin
            nxt_phase = PH_INTERM;
          end
        end
      end
      PH_INTERM: begin
        if (dominant) begin
          if (int_last) begin
            evt.sof   = 1'b1;
            evt.grant = tx_pending;
          end else begin
            evt.ovld  = 1'b1;
          end
          nxt_phase = PH_FRAME;
        end else if (int_last) begin
          nxt_phase = suspend_due ? PH_SUSP : PH_IDLE;
        end
      end
      PH_SUSP: begin
        if (dominant) begin
          evt.sof   = 1'b1;
          nxt_phase = PH_FRAME;
        end else if (susp_last) begin
          nxt_phase = PH_IDLE;
        end
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  // restart the bit index on every phase change
  assign idx_clr = (nxt_phase != phase);
endmodule

// File: rtl/ifs_event_reg.sv
module ifs_event_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] ev_in,
  output logic [N-1:0] ev_q
);
  for (genvar g = 0; g < N; g++) begin : g_evt
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= tick & ev_in[g];
    end
    assign ev_q[g] = q;
  end
endmodule

// File: rtl/can_ifs_seq.sv
module can_ifs_seq
  import can_ifs_pkg::*;
#(
  parameter int unsigned INTERM_LEN  = 3,
  parameter int unsigned SUSPEND_LEN = 8,
  parameter int unsigned DELIM_LEN   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rx_bit,
  input  logic       err_passive,
  input  logic       was_transmitter,
  input  logic       tx_pending,
  input  logic       frame_done,
  input  logic       delim_begin,
  output logic       sof_det,
  output logic       tx_grant,
  output logic       ovld_req,
  output logic [2:0] phase
);
  localparam int unsigned MAX_A  = (INTERM_LEN > SUSPEND_LEN) ? INTERM_LEN : SUSPEND_LEN;
  localparam int unsigned MAX_L  = (MAX_A > DELIM_LEN) ? MAX_A : DELIM_LEN;
  localparam int unsigned CW     = (MAX_L > 1) ? $clog2(MAX_L) : 1;

  ifs_phase_e    phase_q;
  ifs_phase_e    phase_d;
  ifs_phase_e    nxt_phase;
  logic [CW-1:0] idx;
  logic          idx_clr;
  ifs_evt_t      evt;
  logic [EVT_W-1:0] evt_q;

  ifs_bit_index #(.CW(CW)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (bit_tick),
    .clr   (idx_clr),
    .idx   (idx)
  );

  ifs_phase_ctrl #(
    .INTERM_LEN  (INTERM_LEN),
    .SUSPEND_LEN (SUSPEND_LEN),
    .DELIM_LEN   (DELIM_LEN),
    .CW          (CW)
  ) u_ctrl (
    .phase           (phase_q),
    .idx             (idx),
    .rx_bit          (rx_bit),
    .err_passive     (err_passive),
    .was_transmitter (was_transmitter),
    .tx_pending      (tx_pending),
    .frame_done      (frame_done),
    .delim_begin     (delim_begin),
    .nxt_phase       (nxt_phase),
    .idx_clr         (idx_clr),
    .evt             (evt)
  );

  always_comb begin
    phase_d = phase_q;
    if (bit_tick) phase_d = nxt_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  ifs_event_reg #(.N(EVT_W)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (bit_tick),
    .ev_in (evt),
    .ev_q  (evt_q)
  );

  assign sof_det  = evt_q[2];
  assign tx_grant = evt_q[1];
  assign ovld_req = evt_q[0];
  assign phase    = phase_q;
endmodule

// File: rtl/can_ifs_seq_chk.sv
module can_ifs_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       rx_bit,
  input logic       err_passive,
  input logic       was_transmitter,
  input logic       tx_pending,
  input logic       frame_done,
  input logic       delim_begin,
  input logic       sof_det,
  input logic       tx_grant,
  input logic       ovld_req,
  input logic [2:0] phase
);
  // R2
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_det || tx_grant || ovld_req) |-> $past(bit_tick));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(phase));

  // R3
  ovld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovld_req |-> (phase == 3'd1) && ($past(phase) == 3'd3 || $past(phase) == 3'd2));

  // R6
  no_suspend_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && bit_tick && !was_transmitter) |=> phase != 3'd4);

  // R7
  suspend_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && bit_tick && !rx_bit) |=> sof_det && !tx_grant && phase == 3'd1);

  // R4
  sof_ovld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_det, ovld_req}));

  // R5
  suspend_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && bit_tick) |=> !tx_grant);
endmodule

bind can_ifs_seq can_ifs_seq_chk u_chk (.*);

// File: tb/tb_can_ifs_seq.sv
module tb_can_ifs_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic bit_tick, rx_bit, err_passive, was_transmitter, tx_pending;
  logic frame_done, delim_begin;
  logic sof_det, tx_grant, ovld_req;
  logic [2:0] phase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_ifs_seq dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .err_passive(err_passive), .was_transmitter(was_transmitter),
    .tx_pending(tx_pending), .frame_done(frame_done), .delim_begin(delim_begin),
    .sof_det(sof_det), .tx_grant(tx_grant), .ovld_req(ovld_req), .phase(phase)
  );

  // row: {frame_done, delim_begin, rx, err_passive, was_tx, pending, phase[2:0], sof, grant, ovld}
  localparam int NV = 51;
  localparam logic [11:0] VEC [0:NV-1] = '{
    // R8 idle SOF, then R10 plain intermission to idle, R8 grant
    12'b000000_001_100, 12'b101000_011_000, 12'b001000_011_000, 12'b001000_011_000,
    12'b001000_000_000, 12'b001001_001_010,
    // R5 error-passive transmitter: suspend of eight bits
    12'b101000_011_000, 12'b001111_011_000, 12'b001111_011_000, 12'b001111_100_000,
    12'b001111_100_000, 12'b001111_100_000, 12'b001111_100_000, 12'b001111_100_000,
    12'b001111_100_000, 12'b001111_100_000, 12'b001111_100_000, 12'b001111_000_000,
    12'b001111_001_010,
    // R6 error-passive after lost arbitration: no suspend
    12'b101000_011_000, 12'b001101_011_000, 12'b001101_011_000, 12'b001101_000_000,
    12'b001101_001_010,
    // R4 third bit dominant, lost arbitration, pending: join
    12'b101000_011_000, 12'b001101_011_000, 12'b001101_011_000, 12'b000101_001_110,
    // R3 first and second bit dominant
    12'b101000_011_000, 12'b000000_001_001,
    12'b101000_011_000, 12'b001000_011_000, 12'b000000_001_001,
    // R7 dominant inside suspend
    12'b101000_011_000, 12'b001110_011_000, 12'b001110_011_000, 12'b001110_100_000,
    12'b001110_100_000, 12'b001110_100_000, 12'b000111_001_100,
    // R4 third bit dominant, nothing pending
    12'b101000_011_000, 12'b001000_011_000, 12'b001000_011_000, 12'b000000_001_100,
    // R10 strobes ignored in idle, then R8 dominant with pending
    12'b101000_011_000, 12'b001000_011_000, 12'b001000_011_000, 12'b001000_000_000,
    12'b101000_000_000, 12'b011000_000_000, 12'b000001_001_110
  };

  function automatic string tag_of(int i);
    if (i < 6)  return "R8";
    if (i < 19) return "R5";
    if (i < 24) return "R6";
    if (i < 28) return "R4";
    if (i < 33) return "R3";
    if (i < 40) return "R7";
    if (i < 44) return "R4";
    return "R10";
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (phase,sof,grant,ovld)", req, act, exp);
    end
  endtask

  task automatic step(logic fd, logic db, logic rx, logic ep, logic wt, logic pd);
    @(negedge clk);
    frame_done = fd; delim_begin = db; rx_bit = rx;
    err_passive = ep; was_transmitter = wt; tx_pending = pd;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; frame_done = 1'b0; delim_begin = 1'b0;
  endtask

  function automatic logic [5:0] obs();
    return {phase, sof_det, tx_grant, ovld_req};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; rx_bit = 1'b1; err_passive = 1'b0;
    was_transmitter = 1'b0; tx_pending = 1'b0; frame_done = 1'b0; delim_begin = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", obs(), 6'b000_000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", obs(), 6'b000_000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      check(tag_of(i), obs(), VEC[i][5:0]);
    end

    // R2: the pulse from the last row clears one clock later
    @(negedge clk);
    check("R2", obs(), 6'b001_000);

    // R9: delimiter with dominant eighth bit
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", obs(), 6'b010_000);
    for (int k = 0; k < 7; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", obs(), 6'b010_000);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", obs(), 6'b001_001);

    // R9: recessive delimiter leads into intermission, then idle
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 7; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", obs(), 6'b010_000);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", obs(), 6'b011_000);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", obs(), 6'b000_000);

    // R2: no tick, dominant bus and pending request change nothing
    rx_bit = 1'b0; tx_pending = 1'b1;
    repeat (4) @(negedge clk);
    check("R2", obs(), 6'b000_000);
    rx_bit = 1'b1; tx_pending = 1'b0;

    // R1: reset in the middle of suspend returns to idle
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R5", obs(), 6'b100_000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", obs(), 6'b000_000);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule